// File: doc/BRIEF.md
# Serial Port Register Front End

This block presents a small byte-wide register file to a host bus and makes it look like a basic 8250-class serial port. It does not serialise anything. Bytes that the host writes to the data port leave on a one-cycle transmit strobe. Bytes waiting on an incoming stream are offered to the host through the data port and line status. A single level interrupt line tells the host when a received byte is waiting or when the transmitter is ready for more.

Readiness of the transmitter is modelled and not measured. After each data write, a restartable down-counter runs for `TX_DELAY` clocks. When it expires, the transmit interrupt becomes pending. A host driver that probes the modem control register with the loopback test pattern gets a fixed reply. A bus access that addresses a register outside the eight decoded offsets sets a sticky error flag.

Bus accesses take one cycle. Read data is registered and appears on `bus_rdata` in the cycle after the access. `bus_rdata` is zero in every other cycle. When a bus access falls in the same cycle as a timer expiry or a receive arrival, the bus access is applied last and takes precedence.

Top module: `sio_regfile`

## Requirements
- R1: After synchronous reset, every register is 0, `irq`, `tx_strobe` and `err_flag` are low, and a read of offset 5 returns 0x60.
- R2: While line control bit 7 is set, reads of offsets 0 and 1 return 0 and do not pop the receive stream. Writes to offsets 0 and 1 produce no strobe and leave the interrupt enable unchanged.
- R3: Offset 1 reads back the last byte written there. Enable bit 0 enables the receive interrupt and bit 1 enables the transmit interrupt.
- R4: A read of offset 5 returns 0x60, with bit 0 set exactly when `rx_valid` is high.
- R5: A write to offset 0 pulses `tx_strobe` for one cycle, with the byte on `tx_data`. It also clears the transmit pending flag and drops `irq` in the next cycle.
- R6: If the transmit enable is set when offset 0 is written, then `TX_DELAY` cycles after that write the transmit pending flag is set and `irq` rises. A further data write restarts the count.
- R7: A write to offset 1 sets `irq` if the new bit 1 is set, or if the new bit 0 is set and `rx_valid` is high. Otherwise the write drops `irq` and cancels the delay count.
- R8: A write to offset 1 clears the transmit pending flag when the new bit 1 is clear. It clears the receive pending flag unless the new bit 0 is set and `rx_valid` is high. It never sets either flag.
- R9: A read of offset 0 returns the waiting byte and pops it through `rx_ready`, or returns 0 when no byte is waiting. In the next cycle `irq` is held high if `rx_valid` is high again; otherwise `irq` and the receive pending flag are cleared.
- R10: A read of offset 2 returns 1 when either pending flag is set, and 0 otherwise.
- R11: Offset 3 reads back its last write. Offsets 6 and 7 read 0. Writes to offsets 2, 5, 6 and 7 change nothing.
- R12: Writing 0x1A to offset 4 makes it read back 0x9A. Any other written value leaves offset 4 unchanged.
- R13: A rising edge of `rx_valid` while enable bit 0 is set sets the receive pending flag and raises `irq`.
- R14: An access to an offset of 8 or more reads 0 and sets `err_flag`. `err_flag` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_off | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered, valid the cycle after a read |
| rx_data | input | 8 | Byte offered by the receive stream |
| rx_valid | input | 1 | Receive stream has a byte waiting |
| rx_ready | output | 1 | Pops the offered byte this cycle |
| tx_data | output | 8 | Last byte sent |
| tx_strobe | output | 1 | One-cycle pulse per sent byte |
| irq | output | 1 | Level interrupt request |
| err_flag | output | 1 | Sticky undecoded-offset flag |

## Verification
The bench goes after the places where the interrupt line and the pending flags diverge:

- **Interrupt enable written while data waits.** This raises `irq` but leaves the identification read at 0. A design that sets the pending flag on this write would report 1.
- **Delay timer length and restart.** The bench measures the expiry exactly and confirms that a second data write restarts the count. An off-by-one counter, or one that is not restarted, shows up as a wrong cycle count.
- **Receive-drain sequence.** The bench checks that `irq` stays high between two queued bytes and falls after the last one. A design that decides on the popped byte instead of the following cycle's `rx_valid` drops the line early.
- **Divisor-latch select.** With line control bit 7 set, the bench confirms that offsets 0 and 1 neither strobe, pop, nor alter the enable byte.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [2:0] {
    OFF_DATA  = 3'd0,
    OFF_IEN   = 3'd1,
    OFF_IID   = 3'd2,
    OFF_LCTL  = 3'd3,
    OFF_MCTL  = 3'd4,
    OFF_LSTAT = 3'd5,
    OFF_MSTAT = 3'd6,
    OFF_SCR   = 3'd7
  } sio_off_e;

  localparam int IEN_RX_BIT  = 0;
  localparam int IEN_TX_BIT  = 1;
  localparam int LCTL_DL_BIT = 7;

  localparam logic [7:0] MCTL_PROBE_IN  = 8'h1A;
  localparam logic [7:0] MCTL_PROBE_OUT = 8'h9A;
  localparam logic [7:0] LSTAT_IDLE     = 8'h60;
endpackage

// File: rtl/sio_delay_timer.sv
// Restartable down-counter; expire is high in the last counting cycle.
module sio_delay_timer #(
  parameter int DELAY = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cancel,
  output logic expire
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || cancel)      cnt <= '0;
    else if (start)         cnt <= CW'(DELAY);
    else if (cnt != '0)     cnt <= cnt - CW'(1);
  end

  assign expire = (cnt == CW'(1));
endmodule

// File: rtl/sio_rx_watch.sv
// Detects arrival of receive data and flags the cycle after a data-port read.
module sio_rx_watch (
  input  logic clk,
  input  logic rst,
  input  logic rx_valid,
  input  logic rd_taken,
  output logic arrive,
  output logic follow
);
  logic valid_d;
  logic taken_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_d <= 1'b0;
      taken_d <= 1'b0;
    end else begin
      valid_d <= rx_valid;
      taken_d <= rd_taken;
    end
  end

  assign arrive = rx_valid & ~valid_d;
  assign follow = taken_d;
endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
  import sio_pkg::*;
#(
  parameter int TX_DELAY = 300,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_off,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_strobe,
  output logic              irq,
  output logic              err_flag
);
  localparam int REG_AW = 3;

  logic [7:0] lcr_q, ier_q, mcr_q;
  logic       txp_q, rxp_q;
  logic       txp_n, rxp_n, irq_n;
  logic [7:0] rdata_n;

  logic     hit, wr, rd, dl;
  logic     data_wr, ien_wr, data_rd;
  logic     t_start, t_cancel, t_expire;
  logic     arrive, follow;
  logic     ien_raise;
  sio_off_e sel;

  assign hit = bus_en & ((bus_off >> REG_AW) == '0);
  assign wr  = hit & bus_we;
  assign rd  = hit & ~bus_we;
  assign sel = sio_off_e'(bus_off[REG_AW-1:0]);
  assign dl  = lcr_q[LCTL_DL_BIT];

  assign data_wr = wr & (sel == OFF_DATA) & ~dl;
  assign ien_wr  = wr & (sel == OFF_IEN) & ~dl;
  assign data_rd = rd & (sel == OFF_DATA) & ~dl;
  assign rx_ready = data_rd & rx_valid;

  assign ien_raise = bus_wdata[IEN_TX_BIT] | (bus_wdata[IEN_RX_BIT] & rx_valid);
  assign t_start   = data_wr & ier_q[IEN_TX_BIT];
  assign t_cancel  = ien_wr & ~ien_raise;

  sio_delay_timer #(.DELAY(TX_DELAY)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (t_start),
    .cancel (t_cancel),
    .expire (t_expire)
  );

  sio_rx_watch u_rxw (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rd_taken (data_rd),
    .arrive   (arrive),
    .follow   (follow)
  );

  // Event ordering: post-read follow-up, timer expiry, arrival, then the bus access.
  always_comb begin
    txp_n = txp_q;
    rxp_n = rxp_q;
    irq_n = irq;
    if (follow) begin
      if (rx_valid) irq_n = 1'b1;
      else begin
        rxp_n = 1'b0;
        irq_n = 1'b0;
      end
    end
    if (t_expire && ier_q[IEN_TX_BIT]) begin
      txp_n = 1'b1;
      irq_n = 1'b1;
    end
    if (arrive && ier_q[IEN_RX_BIT]) begin
      rxp_n = 1'b1;
      irq_n = 1'b1;
    end
    if (data_wr) begin
      txp_n = 1'b0;
      irq_n = 1'b0;
    end
    if (ien_wr) begin
      irq_n = ien_raise;
      if (!bus_wdata[IEN_TX_BIT]) txp_n = 1'b0;
      if (!(bus_wdata[IEN_RX_BIT] && rx_valid)) rxp_n = 1'b0;
    end
  end

  always_comb begin
    rdata_n = 8'h00;
    if (rd) begin
      case (sel)
        OFF_DATA:  rdata_n = (dl || !rx_valid) ? 8'h00 : rx_data;
        OFF_IEN:   rdata_n = dl ? 8'h00 : ier_q;
        OFF_IID:   rdata_n = {7'b0, txp_q | rxp_q};
        OFF_LCTL:  rdata_n = lcr_q;
        OFF_MCTL:  rdata_n = mcr_q;
        OFF_LSTAT: rdata_n = LSTAT_IDLE | {7'b0, rx_valid};
        default:   rdata_n = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_q     <= '0;
      ier_q     <= '0;
      mcr_q     <= '0;
      txp_q     <= 1'b0;
      rxp_q     <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
      tx_data   <= '0;
      tx_strobe <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      txp_q     <= txp_n;
      rxp_q     <= rxp_n;
      irq       <= irq_n;
      bus_rdata <= rdata_n;
      tx_strobe <= data_wr;
      if (data_wr) tx_data <= bus_wdata;
      if (ien_wr)  ier_q <= bus_wdata;
      if (wr && sel == OFF_LCTL) lcr_q <= bus_wdata;
      if (wr && sel == OFF_MCTL && bus_wdata == MCTL_PROBE_IN) mcr_q <= MCTL_PROBE_OUT;
      if (bus_en && !hit) err_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/sio_regfile_chk.sv
module sio_regfile_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_off,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_strobe,
  input logic              irq,
  input logic              err_flag,
  input logic              dl_sel
);
  p_tx_send_r5: assert property (@(posedge clk) disable iff (rst)
    bus_en && bus_we && bus_off == ADDR_W'(0) && !dl_sel
      |=> tx_strobe && tx_data == $past(bus_wdata) && !irq);

  p_dl_nowrite_r2: assert property (@(posedge clk) disable iff (rst)
    bus_en && bus_we && bus_off == ADDR_W'(0) && dl_sel |=> !tx_strobe);

  p_dl_read_r2: assert property (@(posedge clk) disable iff (rst)
    bus_en && !bus_we && bus_off <= ADDR_W'(1) && dl_sel |=> bus_rdata == 8'h00);

  p_pop_r9: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> rx_valid && !dl_sel);

  p_lsr_r4: assert property (@(posedge clk) disable iff (rst)
    bus_en && !bus_we && bus_off == ADDR_W'(5)
      |=> bus_rdata[7:1] == 7'h30 && bus_rdata[0] == $past(rx_valid));

  p_ien_raise_r7: assert property (@(posedge clk) disable iff (rst)
    bus_en && bus_we && bus_off == ADDR_W'(1) && !dl_sel && bus_wdata[1] |=> irq);

  p_iid_r10: assert property (@(posedge clk) disable iff (rst)
    bus_en && !bus_we && bus_off == ADDR_W'(2) |=> bus_rdata[7:1] == 7'h00);

  p_undec_r14: assert property (@(posedge clk) disable iff (rst)
    bus_en && bus_off > ADDR_W'(7) |=> err_flag && bus_rdata == 8'h00);

  p_err_sticky_r14: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
endmodule

bind sio_regfile sio_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_off   (bus_off),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .tx_data   (tx_data),
  .tx_strobe (tx_strobe),
  .irq       (irq),
  .err_flag  (err_flag),
  .dl_sel    (lcr_q[7])
);

// File: tb/tb_sio_regfile.sv
`timescale 1ns/1ps
module tb_sio_regfile;
  localparam int TXD = 300;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_off = '0;
  logic [7:0] bus_wdata = '0, rx_data = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] bus_rdata, tx_data;
  logic       rx_ready, tx_strobe, irq, err_flag;

  always #10 clk = ~clk;

  sio_regfile #(.TX_DELAY(TXD), .ADDR_W(4)) dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_data(tx_data),
    .tx_strobe(tx_strobe), .irq(irq), .err_flag(err_flag)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] q[$];

  // Behavioural reference state
  logic [7:0] m_lcr, m_ier, m_mcr, m_rd, m_txd;
  bit m_txp, m_rxp, m_irq, m_err, m_txs, m_prev, m_fol, m_rdy;
  int m_cnt;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_rx();
    rx_valid = (q.size() > 0);
    rx_data  = (q.size() > 0) ? q[0] : 8'h00;
  endtask

  task automatic model_reset();
    m_lcr = 0; m_ier = 0; m_mcr = 0; m_rd = 0; m_txd = 0;
    m_txp = 0; m_rxp = 0; m_irq = 0; m_err = 0; m_txs = 0;
    m_prev = 0; m_fol = 0; m_rdy = 0; m_cnt = 0;
  endtask

  task automatic model_step();
    bit v, hit, dl, dwr, iwr, drd, expire, raise;
    logic [7:0] d, r;
    v = (q.size() > 0);
    d = v ? q[0] : 8'h00;
    hit = bus_en && (bus_off < 8);
    dl = m_lcr[7];
    dwr = hit && bus_we && bus_off == 0 && !dl;
    iwr = hit && bus_we && bus_off == 1 && !dl;
    drd = hit && !bus_we && bus_off == 0 && !dl;
    m_rdy = drd && v;
    r = 0;
    if (hit && !bus_we) begin
      case (bus_off)
        0: r = (dl || !v) ? 8'h00 : d;
        1: r = dl ? 8'h00 : m_ier;
        2: r = {7'b0, m_txp | m_rxp};
        3: r = m_lcr;
        4: r = m_mcr;
        5: r = 8'h60 | {7'b0, v};
        default: r = 0;
      endcase
    end
    expire = 0;
    if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) expire = 1;
    end
    if (m_fol) begin
      if (v) m_irq = 1;
      else begin m_rxp = 0; m_irq = 0; end
    end
    if (expire && m_ier[1]) begin m_txp = 1; m_irq = 1; end
    if (v && !m_prev && m_ier[0]) begin m_rxp = 1; m_irq = 1; end
    if (dwr) begin
      m_txp = 0; m_irq = 0;
      if (m_ier[1]) m_cnt = TXD;
    end
    if (iwr) begin
      raise = bus_wdata[1] || (bus_wdata[0] && v);
      m_irq = raise;
      if (!raise) m_cnt = 0;
      if (!bus_wdata[1]) m_txp = 0;
      if (!(bus_wdata[0] && v)) m_rxp = 0;
      m_ier = bus_wdata;
    end
    if (hit && bus_we && bus_off == 3) m_lcr = bus_wdata;
    if (hit && bus_we && bus_off == 4 && bus_wdata == 8'h1A) m_mcr = 8'h9A;
    if (bus_en && !hit) m_err = 1;
    m_txs = dwr;
    if (dwr) m_txd = bus_wdata;
    m_prev = v;
    m_fol = drd;
    m_rd = r;
  endtask

  // One clock: drive at negedge, compare after the edge, return at negedge.
  task automatic cyc(bit en, bit we, int off, int wd, string req);
    bus_en = en; bus_we = we; bus_off = off[3:0]; bus_wdata = wd[7:0];
    #1;
    model_step();
    chk({req, " rx_ready"}, rx_ready, m_rdy);
    @(posedge clk);
    #2;
    chk({req, " irq"}, irq, m_irq);
    chk({req, " rdata"}, bus_rdata, m_rd);
    chk({req, " tx_strobe"}, tx_strobe, m_txs);
    chk({req, " err_flag"}, err_flag, m_err);
    if (m_txs) chk({req, " tx_data"}, tx_data, m_txd);
    if (m_rdy) void'(q.pop_front());
    drive_rx();
    @(negedge clk);
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, req);
  endtask

  task automatic wr(int off, int wd, string req);
    cyc(1, 1, off, wd, req);
  endtask

  task automatic rd(int off, string req);
    cyc(1, 0, off, 0, req);
  endtask

  task automatic wait_irq(string req, int exp);
    int got;
    got = -1;
    for (int k = 1; k <= exp + 5; k++) begin
      idle(1, req);
      if (irq && got < 0) begin got = k; break; end
    end
    chk({req, " delay length"}, got, exp);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 err", err_flag, 0);
    chk("R1 strobe", tx_strobe, 0);
    rd(5, "R1");  chk("R1 lsr", bus_rdata, 8'h60);
    rd(1, "R1");  chk("R1 ien", bus_rdata, 0);
    rd(3, "R1");  chk("R1 lctl", bus_rdata, 0);

    // R3/R7/R10: enable both, no data: irq rises, nothing pending
    wr(1, 8'h03, "R7");
    chk("R7 irq on tx enable", irq, 1);
    rd(1, "R3");  chk("R3 ien readback", bus_rdata, 8'h03);
    rd(2, "R10"); chk("R10 iid idle", bus_rdata, 0);

    // R5/R6 send and delay
    wr(0, 8'h41, "R5");
    chk("R5 strobe", tx_strobe, 1);
    chk("R5 data", tx_data, 8'h41);
    chk("R5 irq low", irq, 0);
    wait_irq("R6", TXD);
    rd(2, "R10"); chk("R10 iid tx pending", bus_rdata, 1);

    // R6 restart
    wr(0, 8'h42, "R6");
    idle(100, "R6");
    wr(0, 8'h43, "R6");
    wait_irq("R6 restart", TXD);

    // R8 transmit pending kept while enabled, dropped when disabled
    wr(1, 8'h02, "R8");
    rd(2, "R8");  chk("R8 tx pending kept", bus_rdata, 1);
    wr(1, 8'h00, "R8");
    chk("R7 irq dropped", irq, 0);
    rd(2, "R8");  chk("R8 tx pending dropped", bus_rdata, 0);

    // R7 cancel running delay
    wr(1, 8'h02, "R7");
    wr(0, 8'h44, "R7");
    idle(50, "R7");
    wr(1, 8'h00, "R7");
    idle(TXD, "R7");
    chk("R7 cancelled timer", irq, 0);

    // R13 arrival, R4 lsr, R9 read and follow-up
    wr(1, 8'h01, "R13");
    chk("R7 no raise without data", irq, 0);
    q.push_back(8'h5A); drive_rx();
    idle(1, "R13");
    chk("R13 irq on arrival", irq, 1);
    rd(2, "R13"); chk("R13 rx pending", bus_rdata, 1);
    rd(5, "R4");  chk("R4 lsr data ready", bus_rdata, 8'h61);
    rd(0, "R9");  chk("R9 byte", bus_rdata, 8'h5A);
    idle(1, "R9");
    chk("R9 irq cleared when drained", irq, 0);
    rd(2, "R9");  chk("R9 rx pending cleared", bus_rdata, 0);
    q.push_back(8'h11); q.push_back(8'h22); drive_rx();
    idle(1, "R13");
    rd(0, "R9");  chk("R9 first", bus_rdata, 8'h11);
    idle(1, "R9");
    chk("R9 irq held with more data", irq, 1);
    rd(0, "R9");  chk("R9 second", bus_rdata, 8'h22);
    idle(1, "R9");
    chk("R9 irq cleared after last", irq, 0);
    rd(0, "R9");  chk("R9 empty read", bus_rdata, 0);
    idle(2, "R9");

    // R8 receive pending handling on enable writes
    q.push_back(8'h77); drive_rx();
    idle(1, "R13");
    wr(1, 8'h00, "R8");
    chk("R7 irq off", irq, 0);
    rd(2, "R8");  chk("R8 rx pending dropped", bus_rdata, 0);
    wr(1, 8'h01, "R7");
    chk("R7 irq on waiting data", irq, 1);
    rd(2, "R8");  chk("R8 enable write sets no flag", bus_rdata, 0);
    rd(0, "R9");  chk("R9 drain", bus_rdata, 8'h77);
    idle(2, "R9");

    // R2 divisor-latch select
    wr(3, 8'h80, "R2");
    q.push_back(8'h99); drive_rx();
    wr(0, 8'h33, "R2");
    chk("R2 no strobe", tx_strobe, 0);
    wr(1, 8'h02, "R2");
    rd(0, "R2");  chk("R2 data read zero", bus_rdata, 0);
    chk("R2 byte still waiting", rx_valid, 1);
    rd(1, "R2");  chk("R2 ien read zero", bus_rdata, 0);
    rd(3, "R11"); chk("R11 lctl readback", bus_rdata, 8'h80);
    wr(3, 8'h03, "R2");
    rd(1, "R2");  chk("R2 ien unchanged", bus_rdata, 8'h01);
    rd(0, "R2");  chk("R2 byte after release", bus_rdata, 8'h99);
    idle(2, "R2");

    // R11 read-only / absent registers
    wr(7, 8'h55, "R11");
    rd(7, "R11"); chk("R11 scratch", bus_rdata, 0);
    rd(6, "R11"); chk("R11 modem status", bus_rdata, 0);
    wr(2, 8'hFF, "R11");
    wr(5, 8'h00, "R11");
    rd(2, "R11"); chk("R11 iid after writes", bus_rdata, 0);
    rd(5, "R11"); chk("R11 lsr after write", bus_rdata, 8'h60);

    // R12 loopback probe
    wr(4, 8'h10, "R12");
    rd(4, "R12"); chk("R12 other value ignored", bus_rdata, 0);
    wr(4, 8'h1A, "R12");
    rd(4, "R12"); chk("R12 probe", bus_rdata, 8'h9A);
    wr(4, 8'h00, "R12");
    rd(4, "R12"); chk("R12 unchanged", bus_rdata, 8'h9A);

    // R14 undecoded offsets
    chk("R14 err clear", err_flag, 0);
    rd(9, "R14");  chk("R14 read zero", bus_rdata, 0);
    chk("R14 err set", err_flag, 1);
    wr(12, 8'h0A, "R14");
    idle(3, "R14");
    chk("R14 sticky", err_flag, 1);
    rd(3, "R14");  chk("R14 lctl untouched", bus_rdata, 8'h03);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule